// File: doc/BRIEF.md
# LCD Status Interrupt Line Generator

This block builds the single combined status interrupt line of an LCD controller and turns each low-to-high transition of that line into a one-cycle request. That request sets the LCD-status bit (bit 1, mask 0x02) of an external interrupt flag register. Each cycle the line is rebuilt from several inputs: the current display mode, four status enable bits, the line-compare match flag, a pulse marking the first cycle of horizontal blank, the effective horizontal scroll, a first-scanline flag, a color-model select and the position within the frame.

Each display mode selects one enable bit as its source. Mode 3 (pixel transfer) selects none. A line-compare match with its enable set forces the line high in any mode. Two timing quirks are built in. On the cycle horizontal blank begins, the horizontal-blank source is masked for one scroll alignment. On the color model, the OAM enable also raises the line on one fixed cycle at the end of the last visible line. The line-counter logic, the CPU-side register access and the interrupt controller sit outside this block.

Top module: `lcd_stat_irq`

## Requirements
- R1: While `rst_n` is low, `irq_req` is 0.
- R2: In mode 0 (`mode`=2'b00) with `en_hblank` set, the line rises. `irq_req` is 1 in the cycle after the first cycle in which the line is high.
- R3: Mode 1 (2'b01) takes its source from `en_vblank`, and mode 2 (2'b10) takes its source from `en_oam`. Each produces a request when the line rises.
- R4: Mode 3 (2'b11) contributes no source. With only mode enables set, it never produces a request.
- R5: When `en_lyc` and `lyc_match` are both 1, the line is high in every mode. When either of them is 0, this term adds nothing.
- R6: If `hblank_entry` is 1 in mode 0 and (`scroll_x` + (`first_line` ? 2 : 0)) mod 4 equals 3, the horizontal-blank source is masked for that cycle. When `hblank_entry` is 0, or the sum mod 4 is any other value, the source is not masked.
- R7: When `color_model` is 1 and `en_oam` is 1, the line is high in the cycle where `frame_pos` equals LINES×LINE_LEN+STAT_DELAY−STEP (65664 with the defaults). This injection does not happen when `color_model` is 0 or `en_oam` is 0.
- R8: A request fires only on a low-to-high transition of the line. Sources that overlap and hand the line over to each other across a mode change produce no further request.
- R9: While `lcd_on` is 0, the line is held low and no request fires. If a source is active when `lcd_on` returns to 1, a fresh request fires.
- R10: `irq_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_on | input | 1 | Display enabled |
| mode | input | 2 | Current display mode (0 hblank, 1 vblank, 2 OAM scan, 3 transfer) |
| en_hblank | input | 1 | Horizontal-blank source enable |
| en_vblank | input | 1 | Vertical-blank source enable |
| en_oam | input | 1 | OAM-scan source enable (also gates the end-of-frame injection) |
| en_lyc | input | 1 | Line-compare source enable |
| lyc_match | input | 1 | Line-compare coincidence flag |
| hblank_entry | input | 1 | High on the first cycle of horizontal blank |
| scroll_x | input | SCX_W | Effective horizontal scroll latched for this line |
| first_line | input | 1 | Current line is the first one after the display was enabled |
| color_model | input | 1 | Selects color-model behaviour |
| frame_pos | input | FPOS_W | Cycle position within the frame |
| irq_req | output | 1 | One-cycle request to set interrupt flag bit 1 |

## Verification
On every cycle, the assertions check four things: a request is a single cycle wide, a disabled display never requests, mode 3 on its own stays silent, and a line held high by line compare does not fire again. Other behaviours depend on particular input histories, so only the bench scenarios show them. These are the scroll-alignment masking and the one-cycle delay it adds to the request, the single-cycle injection at the end of line 144 and whether it is gated by model and enable, and sources handing the line to each other across mode changes without a second request.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;

  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_OAM    = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_e;

  // Alignment whose hblank-entry cycle masks the hblank source
  localparam logic [1:0] MASK_ALIGN = 2'd3;

  function automatic logic [1:0] entry_align(input logic [1:0] scx_lo,
                                             input logic       first);
    entry_align = scx_lo + (first ? 2'd2 : 2'd0);
  endfunction

endpackage

// File: rtl/stat_src_select.sv
module stat_src_select
  import lcd_stat_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       en_hblank,
  input  logic       en_vblank,
  input  logic       en_oam,
  input  logic       hblank_entry,
  input  logic [1:0] scx_lo,
  input  logic       first_line,
  output logic       src_line
);

  logic [3:0] mode_src;
  logic       entry_mask;

  assign entry_mask = hblank_entry && (entry_align(scx_lo, first_line) == MASK_ALIGN);

  always_comb begin
    mode_src              = '0;
    mode_src[MODE_HBLANK] = en_hblank && !entry_mask;
    mode_src[MODE_VBLANK] = en_vblank;
    mode_src[MODE_OAM]    = en_oam;
    mode_src[MODE_XFER]   = 1'b0;
  end

  assign src_line = mode_src[mode];

endmodule

// File: rtl/stat_frame_inject.sv
module stat_frame_inject #(
  parameter int FPOS_W     = 17,
  parameter int INJECT_POS = 65664
) (
  input  logic              color_model,
  input  logic              en_oam,
  input  logic [FPOS_W-1:0] frame_pos,
  output logic              inject
);

  localparam logic [FPOS_W-1:0] POS_MATCH = FPOS_W'(INJECT_POS);

  assign inject = color_model && en_oam && (frame_pos == POS_MATCH);

endmodule

// File: rtl/stat_edge_reg.sv
module stat_edge_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic lcd_on,
  input  logic line_in,
  output logic irq_req
);

  logic line_q, line_d;
  logic req_q, req_d;

  always_comb begin
    line_d = lcd_on && line_in;
    req_d  = line_d && !line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      req_q  <= req_d;
    end
  end

  assign irq_req = req_q;

endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq #(
  parameter int SCX_W      = 8,
  parameter int FPOS_W     = 17,
  parameter int LINES      = 144,
  parameter int LINE_LEN   = 456,
  parameter int STAT_DELAY = 4,
  parameter int STEP       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  input  logic [1:0]        mode,
  input  logic              en_hblank,
  input  logic              en_vblank,
  input  logic              en_oam,
  input  logic              en_lyc,
  input  logic              lyc_match,
  input  logic              hblank_entry,
  input  logic [SCX_W-1:0]  scroll_x,
  input  logic              first_line,
  input  logic              color_model,
  input  logic [FPOS_W-1:0] frame_pos,
  output logic              irq_req
);

  localparam int INJECT_POS = LINES * LINE_LEN + STAT_DELAY - STEP;

  logic src_line, inject, lyc_force, line_now;

  stat_src_select u_src (
    .mode         (mode),
    .en_hblank    (en_hblank),
    .en_vblank    (en_vblank),
    .en_oam       (en_oam),
    .hblank_entry (hblank_entry),
    .scx_lo       (scroll_x[1:0]),
    .first_line   (first_line),
    .src_line     (src_line)
  );

  stat_frame_inject #(
    .FPOS_W     (FPOS_W),
    .INJECT_POS (INJECT_POS)
  ) u_inj (
    .color_model (color_model),
    .en_oam      (en_oam),
    .frame_pos   (frame_pos),
    .inject      (inject)
  );

  assign lyc_force = en_lyc && lyc_match;
  assign line_now  = src_line || lyc_force || inject;

  stat_edge_reg u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lcd_on  (lcd_on),
    .line_in (line_now),
    .irq_req (irq_req)
  );

endmodule

// File: rtl/lcd_stat_irq_chk.sv
module lcd_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lcd_on,
  input logic [1:0] mode,
  input logic       en_lyc,
  input logic       lyc_match,
  input logic       color_model,
  input logic       irq_req
);

  logic armed, forced_q, forced;

  assign forced = lcd_on && en_lyc && lyc_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      armed    <= 1'b1;
      forced_q <= forced;
    end
  end

  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> !irq_req);

  p_xfer_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !(en_lyc && lyc_match) && !color_model) |=> !irq_req);

  p_held_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && forced && forced_q) |=> !irq_req);

endmodule

bind lcd_stat_irq lcd_stat_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lcd_on      (lcd_on),
  .mode        (mode),
  .en_lyc      (en_lyc),
  .lyc_match   (lyc_match),
  .color_model (color_model),
  .irq_req     (irq_req)
);

// File: tb/test_lcd_stat_irq.sv
module test_lcd_stat_irq;

  localparam int CLK_PERIOD = 10;
  localparam int INJ = 144 * 456 + 4 - 4;

  typedef struct {
    logic exp;
    int   req;
  } item_t;

  logic        clk, rst_n, lcd_on, en_hblank, en_vblank, en_oam, en_lyc, lyc_match;
  logic        hblank_entry, first_line, color_model, irq_req;
  logic [1:0]  mode;
  logic [7:0]  scroll_x;
  logic [16:0] frame_pos;

  item_t sb[$];
  int    n_checks = 0;
  int    n_errors = 0;
  logic  done = 1'b0;

  lcd_stat_irq i_lcd_stat_irq (
    .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .mode(mode),
    .en_hblank(en_hblank), .en_vblank(en_vblank), .en_oam(en_oam),
    .en_lyc(en_lyc), .lyc_match(lyc_match), .hblank_entry(hblank_entry),
    .scroll_x(scroll_x), .first_line(first_line), .color_model(color_model),
    .frame_pos(frame_pos), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: one pushed item per cycle, expected value after the next edge
  task automatic cyc(input logic exp, input int req);
    item_t it;
    it.exp = exp;
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic quiet();
    lcd_on = 1'b1; mode = 2'd2; en_hblank = 1'b0; en_vblank = 1'b0;
    en_oam = 1'b0; en_lyc = 1'b0; lyc_match = 1'b0; hblank_entry = 1'b0;
    scroll_x = '0; first_line = 1'b0; color_model = 1'b0; frame_pos = '0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_checks++;
        if (irq_req !== it.exp) begin
          n_errors++;
          $display("FAIL R%0d: irq_req=%b expected %b at %0t", it.req, irq_req, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    quiet();
    rst_n = 1'b0;
    en_hblank = 1'b1; mode = 2'd0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (irq_req !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: irq_req=%b expected 0 in reset", irq_req);
    end
    quiet();
    rst_n = 1'b1;
    cyc(1'b0, 1);

    // R2 / R10: hblank source rises once
    mode = 2'd0; en_hblank = 1'b1; cyc(1'b1, 2);
    cyc(1'b0, 10);
    en_hblank = 1'b0; cyc(1'b0, 2);

    // R3: vblank and OAM sources
    mode = 2'd1; en_vblank = 1'b1; cyc(1'b1, 3);
    cyc(1'b0, 10);
    en_vblank = 1'b0; cyc(1'b0, 3);
    mode = 2'd2; en_oam = 1'b1; cyc(1'b1, 3);
    en_oam = 1'b0; cyc(1'b0, 3);

    // R4: transfer mode silent
    mode = 2'd3; en_hblank = 1'b1; en_vblank = 1'b1; en_oam = 1'b1; cyc(1'b0, 4);
    cyc(1'b0, 4);
    en_hblank = 1'b0; en_vblank = 1'b0; en_oam = 1'b0;
    lyc_match = 1'b1; cyc(1'b0, 5);

    // R5 then R8: compare forces line, mode handover gives no second edge
    en_lyc = 1'b1; cyc(1'b1, 5);
    mode = 2'd0; en_hblank = 1'b1; cyc(1'b0, 8);
    en_lyc = 1'b0; lyc_match = 1'b0; cyc(1'b0, 8);
    mode = 2'd1; en_vblank = 1'b1; cyc(1'b0, 8);
    quiet(); mode = 2'd3; cyc(1'b0, 8);

    // R6: entry masking by alignment
    mode = 2'd0; en_hblank = 1'b1; hblank_entry = 1'b1; scroll_x = 8'd3; cyc(1'b0, 6);
    hblank_entry = 1'b0; cyc(1'b1, 6);
    mode = 2'd3; cyc(1'b0, 6);
    mode = 2'd0; hblank_entry = 1'b1; scroll_x = 8'd1; first_line = 1'b1; cyc(1'b0, 6);
    hblank_entry = 1'b0; cyc(1'b1, 6);
    mode = 2'd3; cyc(1'b0, 6);
    mode = 2'd0; hblank_entry = 1'b1; scroll_x = 8'd2; first_line = 1'b0; cyc(1'b1, 6);
    mode = 2'd3; hblank_entry = 1'b0; cyc(1'b0, 6);
    mode = 2'd0; hblank_entry = 1'b1; scroll_x = 8'd5; first_line = 1'b1; cyc(1'b0, 6);
    mode = 2'd3; hblank_entry = 1'b0; cyc(1'b0, 6);
    mode = 2'd0; hblank_entry = 1'b1; scroll_x = 8'd7; first_line = 1'b0; cyc(1'b0, 6);
    hblank_entry = 1'b0; lyc_match = 1'b1; en_lyc = 1'b1; cyc(1'b1, 6);
    quiet(); cyc(1'b0, 6);

    // R7: end-of-frame injection
    mode = 2'd1; color_model = 1'b1; en_oam = 1'b1; frame_pos = 17'(INJ); cyc(1'b1, 7);
    frame_pos = 17'(INJ + 1); cyc(1'b0, 7);
    color_model = 1'b0; frame_pos = 17'(INJ); cyc(1'b0, 7);
    color_model = 1'b1; en_oam = 1'b0; cyc(1'b0, 7);
    en_oam = 1'b1; frame_pos = 17'(INJ - 1); cyc(1'b0, 7);
    quiet(); cyc(1'b0, 7);

    // R9: display off holds line low, re-enable gives fresh edge
    mode = 2'd0; en_hblank = 1'b1; lcd_on = 1'b0; cyc(1'b0, 9);
    cyc(1'b0, 9);
    lcd_on = 1'b1; cyc(1'b1, 9);
    lcd_on = 1'b0; cyc(1'b0, 9);
    lcd_on = 1'b1; cyc(1'b1, 9);
    cyc(1'b0, 10);

    quiet();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule